// File: doc/BRIEF.md
# Receive DMA Bus Request Controller

This block sits beside a receive DMA engine. It decides when the engine should ask for the host bus so that it can move data out of a receive FIFO into host memory. It also decides how many quadlets the engine may write in the transaction that follows. It watches four things: the FIFO fill level, a flag that marks a complete packet sitting in the FIFO, the room left in the current host buffer, and two 4-bit configuration values. One value sets how much data must be waiting before a request is raised. The other sets the longest write burst. Both are counted in steps of 16 quadlets.

A request can come from any of three causes: the threshold is met, a whole packet is waiting, or the FIFO already holds more than the host buffer can accept. Once raised, the request stays up until the bus is granted. At grant the burst length is fixed to the smallest of three values: the burst cap, the FIFO level and the host space. Each transfer acknowledge then counts that length down. After the last quadlet the request falls for one cycle, and the trigger conditions are checked again, so bursts can follow one another with a single idle cycle between them. Bus arbitration, address generation and FIFO storage are handled elsewhere.

Top module: `rx_dma_req_ctrl`

## Requirements
- R1: When fifo_level >= 16*(thr_sel+1) and both fifo_level and buf_space are nonzero, bus_req is high one cycle after the inputs are presented.
- R2: With pkt_ready low, fifo_level below 16*(thr_sel+1) and fifo_level <= buf_space, no request is raised.
- R3: With pkt_ready high, a request is raised whatever the threshold, provided fifo_level and buf_space are nonzero.
- R4: When fifo_level > buf_space (with buf_space nonzero), a request is raised whatever the threshold.
- R5: When buf_space is zero or fifo_level is zero, no request is raised, even with pkt_ready high.
- R6: At the grant edge, burst_len takes the value min(16*(burst_sel+1), fifo_level, buf_space). It holds that value from the cycle after grant until the burst ends, and reads 0 at all other times.
- R7: Once raised, bus_req stays high until bus_grant, even if the trigger inputs go away. bus_grant while no request is pending has no effect.
- R8: Each cycle of xfer_ack during a burst moves one quadlet. bus_req and burst_len drop in the cycle after the acknowledge that completes the burst. xfer_ack outside a burst has no effect.
- R9: After a burst ends, bus_req is low for exactly one cycle. If the trigger conditions still hold, it rises again in the next cycle.
- R10: If the computed length is zero at the grant edge, no burst is started: bus_req drops in the next cycle and burst_len stays 0.
- R11: During and just after synchronous reset, bus_req and burst_len are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | LVL_W (10) | Quadlets held in the receive FIFO |
| pkt_ready | input | 1 | A complete packet is in the FIFO |
| buf_space | input | SPACE_W (16) | Quadlets left in the current host buffer |
| bus_grant | input | 1 | Host bus granted |
| xfer_ack | input | 1 | One quadlet written this cycle |
| thr_sel | input | CFG_W (4) | Request threshold step n, threshold 16*(n+1) |
| burst_sel | input | CFG_W (4) | Burst cap step n, cap 16*(n+1) |
| bus_req | output | 1 | Host bus request |
| burst_len | output | CFG_W+5 (9) | Quadlets granted for the current burst |

## Verification
The bench probes both sides of each threshold edge: a level one quadlet short of the threshold, and a level equal to the host space against one just above it. A design that used the wrong comparison would request early or miss the request. It checks that a waiting packet with zero host space or an empty FIFO raises nothing; a design missing that guard would issue an empty burst. It pulls the trigger inputs away while a request waits and sends acknowledges before grant. A design that dropped the request or counted early would then show a short or lost burst. It also zeroes the space at the grant edge and runs two bursts back to back. These catch a design that starts a zero-length burst, or one that leaves bus_req low for longer or shorter than the single cycle between bursts.

// File: rtl/rxreq_pkg.sv
package rxreq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } req_state_e;

    // Reasons that can raise a request, plus the veto
    typedef struct packed {
        logic thresh_hit;
        logic pkt_hit;
        logic spill_hit;
        logic blocked;
    } trig_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rxreq_trigger.sv
module rxreq_trigger
    import rxreq_pkg::*;
#(
    parameter int LVL_W   = 10,
    parameter int SPACE_W = 16,
    parameter int CFG_W   = 4,
    parameter int QLOG    = 4
) (
    input  logic [LVL_W-1:0]   level,
    input  logic               pkt,
    input  logic [SPACE_W-1:0] space,
    input  logic [CFG_W-1:0]   thr_n,
    output trig_t              causes,
    output logic               want
);
    localparam int THR_W = CFG_W + QLOG + 1;
    localparam int CMP_W = imax(imax(LVL_W, SPACE_W), THR_W) + 1;

    logic [CMP_W-1:0] lvl_x;
    logic [CMP_W-1:0] spc_x;
    logic [CMP_W-1:0] thr_quads;

    always_comb begin
        lvl_x     = CMP_W'(level);
        spc_x     = CMP_W'(space);
        thr_quads = (CMP_W'(thr_n) + CMP_W'(1)) << QLOG;

        causes.thresh_hit = (lvl_x >= thr_quads);
        causes.pkt_hit    = pkt;
        causes.spill_hit  = (lvl_x > spc_x);
        causes.blocked    = (space == '0) || (level == '0);

        want = !causes.blocked &&
               (causes.thresh_hit || causes.pkt_hit || causes.spill_hit);
    end

endmodule

// File: rtl/rxreq_sizer.sv
module rxreq_sizer
    import rxreq_pkg::*;
#(
    parameter int LVL_W   = 10,
    parameter int SPACE_W = 16,
    parameter int CFG_W   = 4,
    parameter int QLOG    = 4,
    parameter int BLEN_W  = CFG_W + QLOG + 1
) (
    input  logic [LVL_W-1:0]   level,
    input  logic [SPACE_W-1:0] space,
    input  logic [CFG_W-1:0]   burst_n,
    output logic [BLEN_W-1:0]  len
);
    localparam int CMP_W = imax(imax(LVL_W, SPACE_W), BLEN_W) + 1;

    logic [CMP_W-1:0] cap;
    logic [CMP_W-1:0] lvl_x;
    logic [CMP_W-1:0] spc_x;
    logic [CMP_W-1:0] data_lim;
    logic [CMP_W-1:0] smallest;

    always_comb begin
        cap      = (CMP_W'(burst_n) + CMP_W'(1)) << QLOG;
        lvl_x    = CMP_W'(level);
        spc_x    = CMP_W'(space);
        data_lim = (lvl_x < spc_x) ? lvl_x : spc_x;
        smallest = (data_lim < cap) ? data_lim : cap;
        // smallest never exceeds cap, which fits BLEN_W bits
        len      = BLEN_W'(smallest);
    end

endmodule

// File: rtl/rxreq_burst_fsm.sv
module rxreq_burst_fsm
    import rxreq_pkg::*;
#(
    parameter int BLEN_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              want,
    input  logic              grant,
    input  logic              ack,
    input  logic [BLEN_W-1:0] len_in,
    output logic              bus_req,
    output logic [BLEN_W-1:0] burst_len
);
    req_state_e        state;
    logic [BLEN_W-1:0] len_q;
    logic [BLEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            len_q  <= '0;
            remain <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (want) state <= ST_REQ;
                end
                ST_REQ: begin
                    if (grant) begin
                        if (len_in != '0) begin
                            state  <= ST_XFER;
                            len_q  <= len_in;
                            remain <= len_in;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_XFER: begin
                    if (ack) begin
                        if (remain == BLEN_W'(1)) begin
                            state  <= ST_IDLE;
                            len_q  <= '0;
                            remain <= '0;
                        end else begin
                            remain <= remain - BLEN_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign bus_req   = (state != ST_IDLE);
    assign burst_len = len_q;

    // R7: a pending request survives until grant
    a_r7_hold_until_grant: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REQ && !grant) |=> bus_req);

    // R8: request falls right after the completing acknowledge
    a_r8_drop_after_last: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER && ack && remain == BLEN_W'(1)) |=> !bus_req);

    // R6: granted length does not move during a burst
    a_r6_len_steady: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER && !(ack && remain == BLEN_W'(1))) |=> $stable(burst_len));

    // R10: an active burst never has zero length or an overrun count
    a_r10_no_empty_burst: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER) |-> (burst_len != '0 && remain != '0 && remain <= burst_len));

endmodule

// File: rtl/rx_dma_req_ctrl.sv
module rx_dma_req_ctrl
    import rxreq_pkg::*;
#(
    parameter int LVL_W   = 10,
    parameter int SPACE_W = 16,
    parameter int CFG_W   = 4,
    parameter int QLOG    = 4,
    localparam int BLEN_W = CFG_W + QLOG + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LVL_W-1:0]   fifo_level,
    input  logic               pkt_ready,
    input  logic [SPACE_W-1:0] buf_space,
    input  logic               bus_grant,
    input  logic               xfer_ack,
    input  logic [CFG_W-1:0]   thr_sel,
    input  logic [CFG_W-1:0]   burst_sel,
    output logic               bus_req,
    output logic [BLEN_W-1:0]  burst_len
);
    trig_t             causes;
    logic              want;
    logic [BLEN_W-1:0] len_calc;

    rxreq_trigger #(
        .LVL_W(LVL_W), .SPACE_W(SPACE_W), .CFG_W(CFG_W), .QLOG(QLOG)
    ) u_trigger (
        .level  (fifo_level),
        .pkt    (pkt_ready),
        .space  (buf_space),
        .thr_n  (thr_sel),
        .causes (causes),
        .want   (want)
    );

    rxreq_sizer #(
        .LVL_W(LVL_W), .SPACE_W(SPACE_W), .CFG_W(CFG_W), .QLOG(QLOG), .BLEN_W(BLEN_W)
    ) u_sizer (
        .level   (fifo_level),
        .space   (buf_space),
        .burst_n (burst_sel),
        .len     (len_calc)
    );

    rxreq_burst_fsm #(
        .BLEN_W(BLEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .want      (want),
        .grant     (bus_grant),
        .ack       (xfer_ack),
        .len_in    (len_calc),
        .bus_req   (bus_req),
        .burst_len (burst_len)
    );

    // R5: with no host space an idle controller stays idle
    a_r5_blocked_no_req: assert property (@(posedge clk) disable iff (rst)
        (!bus_req && buf_space == '0) |=> !bus_req);

    // R6: the length on the port never exceeds the largest programmable cap
    a_r6_len_limit: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (burst_len <= BLEN_W'((1 << CFG_W) << QLOG)));

endmodule

// File: tb/test_rx_dma_req_ctrl.sv
module test_rx_dma_req_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  fifo_level;
    logic        pkt_ready;
    logic [15:0] buf_space;
    logic        bus_grant;
    logic        xfer_ack;
    logic [3:0]  thr_sel;
    logic [3:0]  burst_sel;
    logic        bus_req;
    logic [8:0]  burst_len;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rx_dma_req_ctrl i_rx_dma_req_ctrl (
        .clk(clk), .rst(rst), .fifo_level(fifo_level), .pkt_ready(pkt_ready),
        .buf_space(buf_space), .bus_grant(bus_grant), .xfer_ack(xfer_ack),
        .thr_sel(thr_sel), .burst_sel(burst_sel), .bus_req(bus_req), .burst_len(burst_len)
    );

    typedef struct packed {
        logic [9:0]  lvl;
        logic        pkt;
        logic [15:0] spc;
        logic [3:0]  thr;
        logic [3:0]  bst;
        logic        req;
        logic [8:0]  len;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{10'd15,  1'b0, 16'd1000, 4'd0,  4'd7,  1'b0, 9'd0},
        '{10'd16,  1'b0, 16'd1000, 4'd0,  4'd7,  1'b1, 9'd16},
        '{10'd200, 1'b0, 16'd1000, 4'd0,  4'd7,  1'b1, 9'd128},
        '{10'd40,  1'b0, 16'd1000, 4'd2,  4'd7,  1'b0, 9'd0},
        '{10'd40,  1'b1, 16'd1000, 4'd2,  4'd7,  1'b1, 9'd40},
        '{10'd30,  1'b0, 16'd20,   4'd15, 4'd7,  1'b1, 9'd20},
        '{10'd300, 1'b0, 16'd1000, 4'd15, 4'd15, 1'b1, 9'd256},
        '{10'd20,  1'b1, 16'd0,    4'd0,  4'd7,  1'b0, 9'd0},
        '{10'd0,   1'b1, 16'd100,  4'd0,  4'd7,  1'b0, 9'd0},
        '{10'd50,  1'b0, 16'd1000, 4'd0,  4'd0,  1'b1, 9'd16},
        '{10'd10,  1'b0, 16'd10,   4'd0,  4'd7,  1'b0, 9'd0},
        '{10'd11,  1'b0, 16'd10,   4'd0,  4'd7,  1'b1, 9'd10}
    };
    localparam string TAGS [NV] = '{
        "R2", "R1", "R6", "R2", "R3", "R4", "R6", "R5", "R5", "R6", "R2", "R4"
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        fifo_level = '0; pkt_ready = 1'b0; bus_grant = 1'b0; xfer_ack = 1'b0;
    endtask

    // Acknowledge n quadlets; bus_req must be high before the last one
    task automatic run_acks(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            if (k == n - 1) chk({tag, " req before last ack"}, int'(bus_req), 1);
            xfer_ack = 1'b1;
            @(negedge clk);
        end
        xfer_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; quiet(); buf_space = 16'd1000; thr_sel = 4'd0; burst_sel = 4'd7;
        repeat (3) @(negedge clk);
        // R11: reset values
        chk("R11 bus_req in reset", int'(bus_req), 0);
        chk("R11 burst_len in reset", int'(burst_len), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 bus_req after reset", int'(bus_req), 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            fifo_level = VECS[v].lvl; pkt_ready = VECS[v].pkt; buf_space = VECS[v].spc;
            thr_sel = VECS[v].thr; burst_sel = VECS[v].bst;
            @(negedge clk);
            chk({TAGS[v], " request decision"}, int'(bus_req), int'(VECS[v].req));
            if (VECS[v].req) begin
                bus_grant = 1'b1;
                @(negedge clk);
                bus_grant = 1'b0; fifo_level = '0; pkt_ready = 1'b0;
                chk({TAGS[v], " R6 burst_len"}, int'(burst_len), int'(VECS[v].len));
                run_acks(TAGS[v], int'(VECS[v].len));
                chk({TAGS[v], " R8 req after burst"}, int'(bus_req), 0);
                chk({TAGS[v], " R6 len after burst"}, int'(burst_len), 0);
            end else begin
                quiet();
                @(negedge clk);
            end
        end

        // R7: request held while triggers vanish; R8: early acks ignored
        buf_space = 16'd100; thr_sel = 4'd0; burst_sel = 4'd7;
        fifo_level = 10'd32;
        @(negedge clk);
        fifo_level = '0; xfer_ack = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk("R7 request held without grant", int'(bus_req), 1);
        end
        xfer_ack = 1'b0; fifo_level = 10'd20; bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0; fifo_level = '0;
        chk("R8 len unaffected by early acks", int'(burst_len), 20);
        run_acks("R8", 20);
        chk("R8 request drops after full count", int'(bus_req), 0);

        // R7: grant while idle does nothing
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
        chk("R7 idle grant bus_req", int'(bus_req), 0);
        chk("R7 idle grant burst_len", int'(burst_len), 0);

        // R8: acks while idle do nothing
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        chk("R8 idle ack bus_req", int'(bus_req), 0);

        // R10: space zeroed at grant edge
        buf_space = 16'd100; fifo_level = 10'd32;
        @(negedge clk);
        chk("R10 request raised", int'(bus_req), 1);
        buf_space = '0; bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
        chk("R10 no burst bus_req", int'(bus_req), 0);
        chk("R10 no burst burst_len", int'(burst_len), 0);
        @(negedge clk);
        chk("R10 stays idle with zero space", int'(bus_req), 0);
        quiet(); buf_space = 16'd1000;
        @(negedge clk);

        // R9: back-to-back bursts
        burst_sel = 4'd0; thr_sel = 4'd0; fifo_level = 10'd64;
        @(negedge clk);
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
        chk("R9 first burst len", int'(burst_len), 16);
        run_acks("R9", 16);
        chk("R9 one idle cycle", int'(bus_req), 0);
        @(negedge clk);
        chk("R9 request again", int'(bus_req), 1);
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0; fifo_level = '0;
        chk("R9 second burst len", int'(burst_len), 16);
        run_acks("R9", 16);
        @(negedge clk);
        chk("R9 idle once triggers gone", int'(bus_req), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule